// File: doc/BRIEF.md
# PLL Configuration Search Engine

This block chooses the multiplier and divider fields of a PLL so that the output comes as close as possible to a requested frequency without exceeding it. Software or a controller presents a parent (reference) rate and a target rate, both as 32-bit integers, and pulses a start input. The engine then steps through every legal field combination, one candidate per clock. A candidate's rate is the parent rate times 2(m+1), divided by (d1+1)·2^d2, with truncating integer division.

The search stops at once on the first candidate whose rate equals the target. Otherwise it runs through the whole space and returns the candidate with the smallest shortfall. When no candidate fits under the target, it reports that no solution exists. The result is a packed configuration word ready to be written to the PLL control register, together with the rate that word produces. A done pulse marks the result, which then stays on the outputs.

Top module: `pll_cfg_search`

## Requirements
- R1: A candidate's rate is floor(parent × 2(m+1) / 2^(d1+d2)). The product is formed without overflow for any 32-bit parent, so the largest parent still gives the correct result.
- R2: Candidates are visited one per clock in this fixed order: d1 from 1 down to 0 (outermost), then d2 from 3 down to 0, then m from 0 up to 127 (innermost). The candidate at position k of this order (k counted from 0) is evaluated in the k-th cycle after start is taken.
- R3: A candidate whose rate is above the target is never selected, and a reported rate never exceeds the target.
- R4: A candidate equal to the target ends the search. done_o rises k+1 cycles after the clock edge that takes start, where k is that candidate's position.
- R5: Without an exact hit, all 1024 candidates are visited and done_o rises 1024 cycles after start is taken. The result is the fitting candidate with the smallest target − rate. A later candidate replaces the current best only if its error is strictly smaller, so the earliest candidate wins a tie.
- R6: cfg_o places m in bits 22:16, d1 in bit 8 and d2 in bits 1:0. Every other bit is 0.
- R7: rate_o equals the rate of the selected candidate, that is, target minus the best error.
- R8: If no candidate fits, nosol_o is 1 and cfg_o and rate_o are 0. Otherwise nosol_o is 0.
- R9: busy_o rises on the edge that takes start and falls on the edge that raises done_o. done_o is high for exactly one cycle. cfg_o, rate_o and nosol_o change only together with done_o.
- R10: A start while busy_o is high is ignored. The running search keeps its captured parent and target and produces exactly one result.
- R11: After reset, busy_o, done_o and nosol_o are 0, and cfg_o and rate_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a search with the present parent and target |
| parent_i | input | 32 | Reference rate |
| target_i | input | 32 | Requested output rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| nosol_o | output | 1 | No candidate fits under the target |
| cfg_o | output | 32 | Packed PLL field word |
| rate_o | output | 32 | Rate produced by cfg_o |

## Verification
The result of an exact hit at order position k is due k+1 cycles after the edge that takes start. A search without an exact hit, or one with no solution, is due exactly 1024 cycles after that edge. The bench records the cycle number when it drives start and stores the expected latency with each expected result. The monitor compares the cycle at which done_o appears against that latency, and it samples on the falling edge so that every registered output has settled. The cases cover an early exact hit, an exact hit deep in the d1 = 0 branch, ties, no solution, a zero parent, the largest parent and a start issued mid-search.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int RATE_W = 32;
  localparam int M_W    = 7;
  localparam int D2_W   = 2;
  localparam int PROD_W = RATE_W + M_W + 1;
  localparam int CFG_W  = 32;
  localparam int M_LSB  = 16;
  localparam int D1_POS = 8;
  localparam int D2_LSB = 0;
  localparam int N_CAND = 2 * (2 ** D2_W) * (2 ** M_W);
  localparam int CNT_W  = $clog2(N_CAND + 1);

  localparam logic [CFG_W-1:0] FIELD_MASK =
      (((CFG_W'(1) << M_W) - CFG_W'(1)) << M_LSB) |
      (CFG_W'(1) << D1_POS) |
      (((CFG_W'(1) << D2_W) - CFG_W'(1)) << D2_LSB);

  typedef logic [RATE_W-1:0] rate_t;

  typedef struct packed {
    logic            d1;
    logic [D2_W-1:0] d2;
    logic [M_W-1:0]  m;
  } cand_t;

  function automatic logic [CFG_W-1:0] pack_cfg(input cand_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[M_LSB +: M_W]   = c.m;
    w[D1_POS]         = c.d1;
    w[D2_LSB +: D2_W] = c.d2;
    return w;
  endfunction
endpackage

// File: rtl/pll_cand_walk.sv
module pll_cand_walk
  import pll_srch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  output cand_t cand_o,
  output logic  last_o
);
  localparam logic [M_W-1:0]  M_MAX  = {M_W{1'b1}};
  localparam logic [D2_W-1:0] D2_MAX = {D2_W{1'b1}};

  cand_t cur_q, cur_d;

  // R2: d1 descends outermost, d2 descends, m ascends innermost
  always_comb begin
    cur_d  = cur_q;
    last_o = (cur_q.d1 == 1'b0) && (cur_q.d2 == '0) && (cur_q.m == M_MAX);
    if (load_i) begin
      cur_d.d1 = 1'b1;
      cur_d.d2 = D2_MAX;
      cur_d.m  = '0;
    end else if (step_i) begin
      if (cur_q.m == M_MAX) begin
        cur_d.m = '0;
        if (cur_q.d2 == '0) begin
          cur_d.d2 = D2_MAX;
          cur_d.d1 = ~cur_q.d1;
        end else begin
          cur_d.d2 = cur_q.d2 - 1'b1;
        end
      end else begin
        cur_d.m = cur_q.m + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else if (load_i || step_i) cur_q <= cur_d;
  end

  assign cand_o = cur_q;
endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
  import pll_srch_pkg::*;
(
  input  rate_t parent_i,
  input  rate_t target_i,
  input  cand_t cand_i,
  output rate_t rate_o,
  output rate_t err_o,
  output logic  fit_o,
  output logic  exact_o
);
  logic [M_W:0]      m_plus;
  logic [M_W+1:0]    factor;
  logic [D2_W:0]     shamt;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;

  // R1: wide product, divide by power of two through a shift
  always_comb begin
    m_plus = {1'b0, cand_i.m} + {{M_W{1'b0}}, 1'b1};
    factor = {m_plus, 1'b0};
    shamt  = {1'b0, cand_i.d2} + {{D2_W{1'b0}}, cand_i.d1};
    prod   = PROD_W'(parent_i) * PROD_W'(factor);
    scaled = prod >> shamt;
  end

  // R3: reject anything above the target
  assign fit_o   = scaled <= PROD_W'(target_i);
  assign exact_o = scaled == PROD_W'(target_i);
  assign rate_o  = scaled[RATE_W-1:0];
  assign err_o   = target_i - scaled[RATE_W-1:0];
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep
  import pll_srch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  step_i,
  input  cand_t cand_i,
  input  rate_t rate_i,
  input  rate_t err_i,
  input  logic  fit_i,
  output logic  sel_valid_o,
  output cand_t sel_cand_o,
  output rate_t sel_rate_o
);
  logic  bv_q, bv_d;
  cand_t bc_q, bc_d;
  rate_t be_q, be_d;
  rate_t br_q, br_d;
  logic  better;

  // R5: strictly smaller error only, so the earliest candidate keeps a tie
  assign better = fit_i && (!bv_q || (err_i < be_q));

  always_comb begin
    sel_valid_o = bv_q || better;
    sel_cand_o  = better ? cand_i : bc_q;
    sel_rate_o  = better ? rate_i : br_q;
  end

  always_comb begin
    bv_d = bv_q;
    bc_d = bc_q;
    be_d = be_q;
    br_d = br_q;
    if (clear_i) begin
      bv_d = 1'b0;
      bc_d = '0;
      be_d = '0;
      br_d = '0;
    end else if (step_i && better) begin
      bv_d = 1'b1;
      bc_d = cand_i;
      be_d = err_i;
      br_d = rate_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bv_q <= 1'b0;
      bc_q <= '0;
      be_q <= '0;
      br_q <= '0;
    end else if (clear_i || step_i) begin
      bv_q <= bv_d;
      bc_q <= bc_d;
      be_q <= be_d;
      br_q <= br_d;
    end
  end
endmodule

// File: rtl/pll_cfg_search.sv
module pll_cfg_search
  import pll_srch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] parent_i,
  input  logic [RATE_W-1:0] target_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              nosol_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic             run_q, run_d;
  rate_t            par_q, tgt_q;
  logic             done_q, done_d;
  logic             nosol_q, nosol_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  rate_t            rate_q, rate_d;

  logic  accept, finish, res_en;
  cand_t cand;
  logic  last;
  rate_t c_rate, c_err;
  logic  c_fit, c_exact;
  logic  s_valid;
  cand_t s_cand;
  rate_t s_rate;

  // R10: start is taken only when idle
  assign accept = start_i && !run_q;
  // R4, R5: stop on an exact hit or after the last candidate
  assign finish = run_q && (c_exact || last);

  pll_cand_walk u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (accept),
    .step_i (run_q),
    .cand_o (cand),
    .last_o (last)
  );

  pll_cand_eval u_eval (
    .parent_i (par_q),
    .target_i (tgt_q),
    .cand_i   (cand),
    .rate_o   (c_rate),
    .err_o    (c_err),
    .fit_o    (c_fit),
    .exact_o  (c_exact)
  );

  pll_best_keep u_best (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .clear_i     (accept),
    .step_i      (run_q),
    .cand_i      (cand),
    .rate_i      (c_rate),
    .err_i       (c_err),
    .fit_i       (c_fit),
    .sel_valid_o (s_valid),
    .sel_cand_o  (s_cand),
    .sel_rate_o  (s_rate)
  );

  always_comb begin
    run_d   = run_q;
    done_d  = finish;
    res_en  = finish;
    nosol_d = nosol_q;
    cfg_d   = cfg_q;
    rate_d  = rate_q;
    if (accept)      run_d = 1'b1;
    else if (finish) run_d = 1'b0;
    if (s_valid) begin
      nosol_d = 1'b0;
      cfg_d   = pack_cfg(s_cand);
      rate_d  = s_rate;
    end else begin
      nosol_d = 1'b1;
      cfg_d   = '0;
      rate_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      par_q <= '0;
      tgt_q <= '0;
    end else if (accept) begin
      par_q <= parent_i;
      tgt_q <= target_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      nosol_q <= 1'b0;
      cfg_q   <= '0;
      rate_q  <= '0;
    end else if (res_en) begin
      nosol_q <= nosol_d;
      cfg_q   <= cfg_d;
      rate_q  <= rate_d;
    end
  end

  assign busy_o  = run_q;
  assign done_o  = done_q;
  assign nosol_o = nosol_q;
  assign cfg_o   = cfg_q;
  assign rate_o  = rate_q;
endmodule

// File: rtl/pll_cfg_search_chk.sv
module pll_cfg_search_chk
  import pll_srch_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              nosol_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [RATE_W-1:0] rate_o,
  input logic [RATE_W-1:0] tgt_q
);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);  // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> !busy_o);  // R9
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);  // R9
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> ($stable(cfg_o) && $stable(rate_o) && $stable(nosol_o)));  // R9
  AST_RATE_NOT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && !nosol_o) |-> (rate_o <= tgt_q));  // R3
  AST_CFG_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> ((cfg_o & ~FIELD_MASK) == '0));  // R6
  AST_NOSOL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && nosol_o) |-> ((cfg_o == '0) && (rate_o == '0)));  // R8
  AST_SEARCH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_cnt <= CNT_W'(N_CAND));  // R5
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && busy_o) |=> $stable(tgt_q));  // R10
endmodule

bind pll_cfg_search pll_cfg_search_chk u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .nosol_o (nosol_o),
  .cfg_o   (cfg_o),
  .rate_o  (rate_o),
  .tgt_q   (tgt_q)
);

// File: tb/pll_cfg_search_tb.sv
module pll_cfg_search_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] parent_i = '0;
  logic [31:0] target_i = '0;
  logic        busy_o, done_o, nosol_o;
  logic [31:0] cfg_o, rate_o;

  pll_cfg_search u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .parent_i(parent_i), .target_i(target_i),
    .busy_o(busy_o), .done_o(done_o), .nosol_o(nosol_o),
    .cfg_o(cfg_o), .rate_o(rate_o)
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  typedef struct {
    logic [31:0] cfg;
    logic [31:0] rate;
    logic        nosol;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input logic [31:0] par, input logic [31:0] tgt);
    exp_t   e;
    longint best_err;
    bit     found;
    int     idx;
    e.cfg = 0; e.rate = 0; e.nosol = 1; e.lat = 1024; e.t0 = 0; e.tag = "";
    found = 0; best_err = 0; idx = 0;
    for (int d1 = 1; d1 >= 0; d1--)
      for (int d2 = 3; d2 >= 0; d2--)
        for (int m = 0; m <= 127; m++) begin
          longint r;
          r = (longint'(par) * longint'(2 * (m + 1))) >>> (d1 + d2);
          idx++;
          if (r <= longint'(tgt)) begin
            if (!found || (longint'(tgt) - r) < best_err) begin
              found = 1;
              best_err = longint'(tgt) - r;
              e.cfg = (32'(m) << 16) | (32'(d1) << 8) | 32'(d2);
              e.rate = 32'(r);
              e.nosol = 0;
            end
            if (r == longint'(tgt)) begin
              e.lat = idx;
              return e;
            end
          end
        end
    return e;
  endfunction

  // Monitor: pops expected results as done_o appears
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (q.size() == 0) begin
        chk(0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cfg_o == e.cfg, {"R6 cfg ", e.tag}, cfg_o, e.cfg);
        chk(rate_o == e.rate, {"R7 rate ", e.tag}, rate_o, e.rate);
        chk(nosol_o == e.nosol, {"R8 nosol ", e.tag}, nosol_o, e.nosol);
        chk((cyc - e.t0) == e.lat + 1, {"R2 R4 R5 latency ", e.tag}, cyc - e.t0, e.lat + 1);
      end
    end
  end

  task automatic run_case(input logic [31:0] par, input logic [31:0] tgt,
                          input string tag, input bit poke);
    exp_t e;
    e = model(par, tgt);
    e.tag = tag;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    parent_i = par;
    target_i = tgt;
    start_i  = 1'b1;
    e.t0 = cyc;
    q.push_back(e);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R9 busy after start ", tag}, busy_o, 1);
    if (poke) begin
      repeat (5) @(negedge clk_i);
      parent_i = 32'd7;
      target_i = 32'd3;
      start_i  = 1'b1;  // R10: must be ignored
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_o == 1'b0, {"R9 done single pulse ", tag}, done_o, 0);
    chk(cfg_o == e.cfg, {"R9 outputs hold ", tag}, cfg_o, e.cfg);
    chk(q.size() == 0, {"R4 result produced ", tag}, q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(busy_o == 0, "R11 busy reset", busy_o, 0);
    chk(done_o == 0, "R11 done reset", done_o, 0);
    chk(nosol_o == 0, "R11 nosol reset", nosol_o, 0);
    chk(cfg_o == 0, "R11 cfg reset", cfg_o, 0);
    chk(rate_o == 0, "R11 rate reset", rate_o, 0);

    // R4: exact at position 7: cfg 0x00070103
    run_case(32'd1000, 32'd1000, "R4 early exact", 0);
    chk(cfg_o == 32'h0007_0103, "R4 R6 early exact word", cfg_o, 32'h0007_0103);
    // R2: exact only in d1=0,d2=0 branch at m=99, position 995
    run_case(32'd1000, 32'd200000, "R2 deep exact", 0);
    chk(cfg_o == 32'h0063_0000, "R2 R6 deep exact word", cfg_o, 32'h0063_0000);
    // R5: tie between 125*8 and 250*4, earliest kept
    run_case(32'd1000, 32'd1100, "R5 tie", 0);
    chk(cfg_o == 32'h0007_0103 && rate_o == 32'd1000, "R5 tie first wins", cfg_o, 32'h0007_0103);
    // R8: target below smallest candidate 125
    run_case(32'd1000, 32'd100, "R8 no solution", 0);
    chk(nosol_o == 1'b1 && rate_o == 0, "R8 nosol flag", nosol_o, 1);
    // R3: all rates 0 with parent 0; target 0 exact at position 0
    run_case(32'd0, 32'd0, "R3 zero parent exact", 0);
    run_case(32'd0, 32'd55, "R3 zero parent inexact", 0);
    // R1: largest parent, truncating shifts
    run_case(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 max parent", 0);
    run_case(32'd1001, 32'd7777, "R1 truncation", 0);
    // R10: start while busy
    run_case(32'd24000000, 32'd600000000, "R10 poke", 1);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] p, t;
      p = $urandom_range(50000000, 1000);
      t = $urandom_range(2000000000, 100);
      run_case(p, t, "R5 random", 0);
    end
    repeat (4) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0, "R10 idle at end", busy_o, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule